// File: doc/BRIEF.md
# Isochronous IN Interval Flush Controller

This block watches one isochronous IN endpoint of a USB device controller. It keeps a frame clock that is driven by received start-of-frame markers. When a marker is missing or damaged, an internal timer supplies the boundary in its place. Frames are grouped into service windows of 2^sel frames. The host is expected to fetch data only in the last frame of each window.

If that expected frame closes without a clean IN token, the flush request is enabled and the transmit buffer still holds data, the block raises a one-cycle clear request toward the FIFO. This clear comes just after the frame boundary, so stale isochronous data is not sent in a later window. The current position inside the window is exported so that the surrounding logic can see where the endpoint stands.

Top module: `iso_in_flush_ctrl`

## Requirements
- R1: While and right after reset, `fifo_clr` is 0 and `phase` is 0.
- R2: With `flush_en` at 0, `fifo_clr` never rises, whatever tokens, data and interval setting are applied.
- R3: With `flush_en` at 1, a boundary that closes the expected frame without a clean token while `fifo_has_data` is 1 sets `fifo_clr` in the cycle right after the boundary cycle.
- R4: An IN token (`in_tok`=1, `tok_err`=0) seen in the expected frame, up to and including the boundary cycle that closes it, prevents the flush at that boundary.
- R5: A token flagged with `tok_err`=1 in the same cycle gives no credit, so the flush still happens.
- R6: Tokens seen in frames other than the expected one (phase below 2^sel-1) give no credit.
- R7: No flush is issued when `fifo_has_data` is 0 in the boundary cycle.
- R8: A frame boundary is a cycle with `sof_ok`=1. It is also a cycle that comes FRAME_CYC+SLACK cycles after the previous boundary with no `sof_ok` in between. `sof_bad` does not create or move a boundary.
- R9: `phase` steps by one at each boundary and returns to 0 at the boundary that closes the frame where it equals 2^sel-1. Frame `phase`=2^sel-1 is the expected frame.
- R10: `clr_req` or `bus_rst` sets `phase` to 0 on the next cycle and drops any credit. A boundary in that same cycle produces no flush.
- R11: `fifo_clr` lasts exactly one cycle, and there is at most one pulse per boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sof_ok | input | 1 | Valid start-of-frame received (pulse) |
| sof_bad | input | 1 | Corrupted start-of-frame seen (pulse) |
| in_tok | input | 1 | IN token addressed to this pipe (pulse) |
| tok_err | input | 1 | Bus error on the token in the same cycle |
| fifo_has_data | input | 1 | Transmit buffer holds a packet |
| intv_sel | input | SEL_W | Window length exponent, window = 2^intv_sel frames |
| flush_en | input | 1 | Enables interval-based flushing |
| clr_req | input | 1 | Software request to clear the interval count (pulse) |
| bus_rst | input | 1 | USB bus reset detected |
| fifo_clr | output | 1 | One-cycle request to clear the transmit buffer |
| phase | output | PH_W | Frame position inside the current window |

## Verification
A wrong boundary timer shows up as a `phase` step that comes too early or too late. This is visible within one frame time, at most FRAME_CYC+SLACK cycles after the last boundary. A lost or stuck token credit, or a bad window position, shows up at the next expected-frame boundary as a missing or extra `fifo_clr`. That is at most 2^sel frames later. A clear that does not take effect shows up in `phase` on the very next cycle.

// File: rtl/iso_flush_pkg.sv
package iso_flush_pkg;

  typedef struct packed {
    logic bnd;    // any frame boundary
    logic synth;  // boundary made by the interpolation timer
  } frame_evt_t;

  // Last phase index of a window of 2^sel frames.
  function automatic logic [31:0] win_mask(input logic [7:0] sel);
    return (32'd1 << sel) - 32'd1;
  endfunction

  // Flush decision at a boundary.
  function automatic logic flush_due(input logic en, input logic at_end,
                                     input logic has_data, input logic served);
    return en & at_end & has_data & ~served;
  endfunction

endpackage

// File: rtl/iso_frame_timer.sv
module iso_frame_timer
  import iso_flush_pkg::*;
#(
  parameter int FRAME_CYC = 48000,
  parameter int SLACK     = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sof_ok,
  input  logic       sof_bad,
  output frame_evt_t evt
);
  localparam int LIM = FRAME_CYC + SLACK;
  localparam int CW  = $clog2(LIM + 1);

  logic [CW-1:0] cnt;
  logic          synth;

  assign synth     = ~sof_ok & (cnt == CW'(LIM - 1));
  assign evt.synth = synth;
  assign evt.bnd   = sof_ok | synth;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (evt.bnd) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  // R8: the gap counter never passes the interpolation limit
  p_gap_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LIM - 1));

  // R8: a real SOF restarts the gap, so no synthetic boundary follows at once
  p_no_synth_after_sof_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sof_ok) |-> !evt.synth);

  // R8: a damaged SOF alone does not make a boundary before the limit
  p_bad_sof_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_bad && !sof_ok && cnt < CW'(LIM - 1)) |-> !evt.bnd);

endmodule

// File: rtl/iso_window_tracker.sv
module iso_window_tracker
  import iso_flush_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter int PH_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bnd,
  input  logic             clear,
  input  logic             in_tok,
  input  logic             tok_err,
  input  logic [SEL_W-1:0] sel,
  output logic [PH_W-1:0]  phase,
  output logic             at_end,
  output logic             served_now
);
  logic [PH_W-1:0] mask;
  logic            served;
  logic            good_tok;

  assign mask       = PH_W'(win_mask(8'(sel)));
  assign at_end     = (phase >= mask);
  assign good_tok   = in_tok & ~tok_err & at_end;
  assign served_now = served | good_tok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= '0;
      served <= 1'b0;
    end else if (clear) begin
      phase  <= '0;
      served <= 1'b0;
    end else if (bnd) begin
      phase  <= at_end ? '0 : phase + 1'b1;
      served <= 1'b0;
    end else begin
      served <= served_now;
    end
  end

  // R10: a clear leaves phase at zero with no credit
  p_clear_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clear) |-> (phase == '0 && !served));

  // R9: phase steps by one at a boundary inside the window
  p_phase_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bnd && !clear && !at_end) |-> phase == $past(phase) + 1'b1);

  // R9: phase holds between boundaries
  p_phase_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!bnd && !clear) |-> $stable(phase));

  // R5: an errored token gives no credit
  p_err_no_credit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_tok && tok_err && !served && !bnd && !clear) |=> !served);

  // R6: a token outside the expected frame gives no credit
  p_early_no_credit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_tok && !at_end && !served && !bnd && !clear) |=> !served);

endmodule

// File: rtl/iso_flush_gen.sv
module iso_flush_gen
  import iso_flush_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bnd,
  input  logic clear,
  input  logic flush_en,
  input  logic at_end,
  input  logic has_data,
  input  logic served_now,
  output logic fifo_clr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fifo_clr <= 1'b0;
    else        fifo_clr <= bnd & ~clear & flush_due(flush_en, at_end, has_data, served_now);
  end

  // R11: the clear request is a single-cycle pulse
  p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> !fifo_clr);

  // R2: nothing is flushed while flushing is disabled
  p_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(flush_en) |-> !fifo_clr);

  // R3: a flush follows a boundary only
  p_on_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |-> $past(bnd));

  // R7: an empty buffer is never flushed
  p_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |-> $past(has_data));

  // R4: a credited expected frame is not flushed
  p_served_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bnd && served_now) |-> !fifo_clr);

  // R10: a clear in the boundary cycle suppresses the flush
  p_clear_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clear) |-> !fifo_clr);

endmodule

// File: rtl/iso_in_flush_ctrl.sv
module iso_in_flush_ctrl
  import iso_flush_pkg::*;
#(
  parameter int FRAME_CYC = 48000,
  parameter int SLACK     = 64,
  parameter int SEL_W     = 3,
  localparam int PH_W     = (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof_ok,
  input  logic             sof_bad,
  input  logic             in_tok,
  input  logic             tok_err,
  input  logic             fifo_has_data,
  input  logic [SEL_W-1:0] intv_sel,
  input  logic             flush_en,
  input  logic             clr_req,
  input  logic             bus_rst,
  output logic             fifo_clr,
  output logic [PH_W-1:0]  phase
);
  frame_evt_t evt;
  logic       clear;
  logic       at_end;
  logic       served_now;

  assign clear = clr_req | bus_rst;

  iso_frame_timer #(.FRAME_CYC(FRAME_CYC), .SLACK(SLACK)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .sof_ok  (sof_ok),
    .sof_bad (sof_bad),
    .evt     (evt)
  );

  iso_window_tracker #(.SEL_W(SEL_W), .PH_W(PH_W)) u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .bnd        (evt.bnd),
    .clear      (clear),
    .in_tok     (in_tok),
    .tok_err    (tok_err),
    .sel        (intv_sel),
    .phase      (phase),
    .at_end     (at_end),
    .served_now (served_now)
  );

  iso_flush_gen u_flush (
    .clk        (clk),
    .rst_n      (rst_n),
    .bnd        (evt.bnd),
    .clear      (clear),
    .flush_en   (flush_en),
    .at_end     (at_end),
    .has_data   (fifo_has_data),
    .served_now (served_now),
    .fifo_clr   (fifo_clr)
  );

  // R1: outputs stay quiet in reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!fifo_clr && phase == '0));

endmodule

// File: tb/test_iso_in_flush_ctrl.sv
`timescale 1ns/1ps
module test_iso_in_flush_ctrl;
  localparam int FC    = 40;
  localparam int SL    = 4;
  localparam int GAP   = FC + SL;
  localparam int SW    = 3;
  localparam int PW    = (1 << SW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sof_ok = 0, sof_bad = 0, in_tok = 0, tok_err = 0;
  logic fifo_has_data = 0, flush_en = 0, clr_req = 0, bus_rst = 0;
  logic [SW-1:0] intv_sel = '0;
  logic fifo_clr;
  logic [PW-1:0] phase;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int m_gap, m_phase;
  bit m_credit, m_clr;
  string lab_clr, lab_ph;

  always #5 clk = ~clk;

  iso_in_flush_ctrl #(.FRAME_CYC(FC), .SLACK(SL), .SEL_W(SW)) i_iso_in_flush_ctrl (
    .clk(clk), .rst_n(rst_n), .sof_ok(sof_ok), .sof_bad(sof_bad),
    .in_tok(in_tok), .tok_err(tok_err), .fifo_has_data(fifo_has_data),
    .intv_sel(intv_sel), .flush_en(flush_en), .clr_req(clr_req),
    .bus_rst(bus_rst), .fifo_clr(fifo_clr), .phase(phase)
  );

  function automatic int last_of_window(input int s);
    return (2 ** s) - 1;
  endfunction

  task automatic check(input string req, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp_v, $time);
    end
  endtask

  // One clock: apply pulses, advance the model, compare after the edge.
  task automatic step(input bit s_ok, input bit s_bad, input bit tok,
                      input bit err, input bit cr, input bit br);
    bit bnd, synth, exp_frame, good, clr_now, nxt;
    sof_ok = s_ok; sof_bad = s_bad; in_tok = tok; tok_err = err;
    clr_req = cr; bus_rst = br;
    synth     = !s_ok && (m_gap == GAP - 1);
    bnd       = s_ok || synth;
    exp_frame = (m_phase >= last_of_window(int'(intv_sel)));
    good      = tok && !err && exp_frame;
    clr_now   = cr || br;
    nxt = bnd && !clr_now && flush_en && exp_frame && fifo_has_data
          && !(m_credit || good);
    if (!bnd)               lab_clr = "R11";
    else if (!flush_en)     lab_clr = "R2";
    else if (clr_now)       lab_clr = "R10";
    else if (!exp_frame)    lab_clr = "R6";
    else if (!fifo_has_data) lab_clr = "R7";
    else if (m_credit || good) lab_clr = "R4";
    else if (tok && err)    lab_clr = "R5";
    else                    lab_clr = "R3";
    lab_ph = clr_now ? "R10" : (synth ? "R8" : "R9");
    @(posedge clk);
    m_gap = bnd ? 0 : m_gap + 1;
    if (clr_now) begin
      m_phase = 0; m_credit = 0;
    end else if (bnd) begin
      m_phase = exp_frame ? 0 : m_phase + 1; m_credit = 0;
    end else begin
      m_credit = m_credit || good;
    end
    m_clr = nxt;
    @(negedge clk);
    check(lab_clr, int'(fifo_clr), int'(m_clr));
    check(lab_ph, int'(phase), m_phase);
    sof_ok = 0; sof_bad = 0; in_tok = 0; tok_err = 0; clr_req = 0; bus_rst = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    void'($urandom(32'h1D5E_0042));
    m_gap = 0; m_phase = 0; m_credit = 0; m_clr = 0;
    repeat (3) @(negedge clk);
    check("R1", int'(fifo_clr), 0);
    check("R1", int'(phase), 0);
    rst_n = 1'b1;
    @(negedge clk);
    m_gap = 1;  // one edge has passed since reset release
    check("R1", int'(fifo_clr), 0);
    check("R1", int'(phase), 0);

    // Directed R8 with R3: no SOF at all, damaged SOF markers ignored,
    // interpolated boundary flushes an unread buffer every frame (sel=0).
    flush_en = 1; fifo_has_data = 1; intv_sel = 0;
    step(0, 1, 0, 0, 0, 0);
    idle(GAP);
    step(0, 1, 0, 0, 0, 0);
    idle(GAP);

    // Directed R4: clean token in the expected frame of a 2-frame window.
    step(1, 0, 0, 0, 1, 0);
    intv_sel = 1;
    step(1, 0, 0, 0, 0, 0);      // phase 0 -> 1
    step(0, 0, 1, 0, 0, 0);      // credit
    idle(5);
    step(1, 0, 0, 0, 0, 0);      // no flush
    // Directed R5: errored token only, then R6: token in early frame.
    idle(3);
    step(1, 0, 0, 0, 0, 0);      // phase -> 1
    step(0, 0, 1, 1, 0, 0);
    step(1, 0, 0, 0, 0, 0);      // flush, phase -> 0
    step(0, 0, 1, 0, 0, 0);      // early token, no credit
    step(1, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0);      // flush
    // Directed R10: bus reset in a boundary cycle suppresses the flush.
    step(1, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 1);
    // Directed R2 and R7.
    flush_en = 0; step(1, 0, 0, 0, 0, 0); step(1, 0, 0, 0, 0, 0);
    flush_en = 1; fifo_has_data = 0; step(1, 0, 0, 0, 0, 0); step(1, 0, 0, 0, 0, 0);

    // Constrained random frames.
    for (int f = 0; f < 120; f++) begin
      bit drop = ($urandom % 5) == 0;
      if (($urandom % 8) == 0) fifo_has_data = ~fifo_has_data;
      if (($urandom % 12) == 0) flush_en = ~flush_en;
      for (int k = 1; k <= FC; k++) begin
        bit tk = ($urandom % 25) == 0;
        bit er = tk && (($urandom % 4) == 0);
        bit cq = ($urandom % 300) == 0;
        bit br = ($urandom % 600) == 0;
        bit so = (k == FC) && !drop;
        bit sb = (k == FC) && drop;
        if (cq) intv_sel = SW'($urandom % 4);
        step(so, sb, tk, er, cq, br);
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule